// File: doc/BRIEF.md
# Periodic Clock Pulse Swallower

This block removes exactly one high pulse from a source clock at a regular interval set by software. A 16-bit control register holds the interval N. Writing a non-zero value while the block is idle arms it. A counter on the source clock then counts the cycles. Each time it closes a group of N cycles, a registered clock enable drops low for one full source period.

A latch that is transparent while the source clock is low captures that enable. The gated clock is the source clock ANDed with the latched enable, so a suppressed pulse is removed whole and no partial pulse can appear.

A value written while swallowing is active does not touch the group in progress. It is held and takes effect at the next suppression. When the held value is 0, swallowing stops after that last suppression and the clock runs continuously again.

Top module: `pulse_swallow_top`

## Requirements
- R1: When the interval is greater than 1, `clk_en` is low for exactly one source cycle at a time and is high again in the following cycle.
- R2: With interval N active, successive low cycles of `clk_en` are exactly N cycles apart. The first low cycle comes N cycles after the edge on which the arming write was taken.
- R3: A write of a non-zero value while idle sets `stretch_active` high on the next cycle, loads the interval and restarts the count from zero.
- R4: A write of 0 while idle leaves the block idle, and `clk_en` stays high.
- R5: After a synchronous reset, `stretch_active` is 0, `ctrl_rdata` is 0 and `clk_en` is 1. While idle, `clk_en` stays 1 and every source pulse appears on `clk_gated`.
- R6: A write while active leaves the current interval and count unchanged until the next low cycle of `clk_en`. At that edge the written value becomes the interval. If that value is 0, `stretch_active` falls and `clk_en` stays high from then on.
- R7: `ctrl_rdata` returns the last value written, starting from the cycle after the write.
- R8: `clk_gated` shows the high phase of a source cycle only if `clk_en` was high during the low phase just before it. Otherwise it stays low for that whole cycle.
- R9: An interval of 1 holds `clk_en` low on every cycle while active, so every pulse is swallowed.
- R10: `stretch_active` is high exactly while swallowing is in effect, from the cycle after the arming write until the edge that applies a held 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 16 | Interval value to write |
| ctrl_rdata | output | 16 | Readback of the last written value |
| stretch_active | output | 1 | Swallowing is currently in effect |
| clk_en | output | 1 | Registered clock enable, low during a swallowed cycle |
| clk_gated | output | 1 | Source clock with the swallowed pulses removed |

## Verification
The bench writes values at many offsets inside a running group, including on the very cycle of a suppression. A design that applied a new interval at once would cut the group short. A design that dropped a write landing on the wrap would keep the old interval. Intervals of 1, 2 and larger values are run, along with a held 0 that ends swallowing; an off-by-one counter would space the gaps N±1 apart, and a design that stopped at once would lose the final suppression. Every rising edge of the gated clock is compared with the enable in effect for that cycle. A gate sampling the enable at the wrong phase would swallow the pulse one cycle late or let it through.

// File: rtl/pulse_swallow_pkg.sv
package pulse_swallow_pkg;
  localparam int unsigned DEF_CTRL_W = 16;

  typedef enum logic {
    SW_IDLE = 1'b0,
    SW_RUN  = 1'b1
  } sw_state_e;
endpackage

// File: rtl/swallow_ctrl_reg.sv
module swallow_ctrl_reg
  import pulse_swallow_pkg::*;
#(
  parameter int unsigned CTRL_W = DEF_CTRL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              wrap_i,
  output logic [CTRL_W-1:0] rdata_o,
  output logic [CTRL_W-1:0] period_o,
  output logic              active_o,
  output logic              restart_o
);
  sw_state_e         state_q;
  logic [CTRL_W-1:0] period_q;
  logic [CTRL_W-1:0] pend_q;
  logic              has_pend_q;
  logic [CTRL_W-1:0] rdata_q;
  logic              arm_now;

  assign arm_now = (state_q == SW_IDLE) && wr_en && (wr_data != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= SW_IDLE;
      period_q   <= '0;
      pend_q     <= '0;
      has_pend_q <= 1'b0;
      rdata_q    <= '0;
    end else begin
      if (wr_en) rdata_q <= wr_data;
      if (state_q == SW_IDLE) begin
        if (arm_now) begin
          state_q    <= SW_RUN;
          period_q   <= wr_data;
          has_pend_q <= 1'b0;
        end
      end else begin
        if (wrap_i && has_pend_q) begin
          period_q   <= pend_q;
          has_pend_q <= 1'b0;
          if (pend_q == '0) state_q <= SW_IDLE;
        end
        if (wr_en) begin
          pend_q     <= wr_data;
          has_pend_q <= 1'b1;
        end
      end
    end
  end

  assign rdata_o   = rdata_q;
  assign period_o  = period_q;
  assign active_o  = (state_q == SW_RUN);
  assign restart_o = arm_now;

  p_arm_load_r3: assert property (@(posedge clk) disable iff (rst)
    (!active_o && wr_en && wr_data != '0) |=> (active_o && period_o == $past(wr_data)));

  p_zero_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (!active_o && wr_en && wr_data == '0) |=> !active_o);

  p_defer_r6: assert property (@(posedge clk) disable iff (rst)
    (active_o && !wrap_i) |=> ($stable(period_o) && active_o));

  p_readback_r7: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (rdata_o == $past(wr_data)));
endmodule

// File: rtl/swallow_counter.sv
module swallow_counter #(
  parameter int unsigned CTRL_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active_i,
  input  logic              restart_i,
  input  logic [CTRL_W-1:0] period_i,
  output logic              wrap_o,
  output logic              en_o
);
  logic [CTRL_W-1:0] cnt_q;
  logic              en_q;
  logic [CTRL_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + {{CTRL_W{1'b0}}, 1'b1};
  assign wrap_o  = active_i && (cnt_inc == {1'b0, period_i});

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      en_q  <= 1'b1;
    end else if (restart_i || !active_i) begin
      cnt_q <= '0;
      en_q  <= 1'b1;
    end else if (wrap_o) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_inc[CTRL_W-1:0];
      en_q  <= 1'b1;
    end
  end

  assign en_o = en_q;

  p_gap_one_cycle_r1: assert property (@(posedge clk) disable iff (rst)
    (!en_q && period_i > 1) |=> en_q);

  p_cnt_below_period_r2: assert property (@(posedge clk) disable iff (rst)
    active_i |-> ({1'b0, cnt_q} < {1'b0, period_i}));

  p_idle_pass_r5: assert property (@(posedge clk) disable iff (rst)
    !active_i |=> en_q);

  p_every_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    (active_i && period_i == 1) |=> !en_q);
endmodule

// File: rtl/swallow_clock_gate.sv
module swallow_clock_gate (
  input  logic clk_i,
  input  logic en_i,
  output logic clk_o
);
  logic en_lat;

  always_latch begin
    if (!clk_i) en_lat = en_i;
  end

  assign clk_o = clk_i & en_lat;
endmodule

// File: rtl/pulse_swallow_top.sv
module pulse_swallow_top
  import pulse_swallow_pkg::*;
#(
  parameter int unsigned CTRL_W = DEF_CTRL_W
) (
  input  logic              clk_src,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] ctrl_rdata,
  output logic              stretch_active,
  output logic              clk_en,
  output logic              clk_gated
);
  logic [CTRL_W-1:0] period_w;
  logic              active_w;
  logic              restart_w;
  logic              wrap_w;
  logic              en_w;

  swallow_ctrl_reg #(.CTRL_W(CTRL_W)) ctrl_i (
    .clk       (clk_src),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .wrap_i    (wrap_w),
    .rdata_o   (ctrl_rdata),
    .period_o  (period_w),
    .active_o  (active_w),
    .restart_o (restart_w)
  );

  swallow_counter #(.CTRL_W(CTRL_W)) cnt_i (
    .clk       (clk_src),
    .rst       (rst),
    .active_i  (active_w),
    .restart_i (restart_w),
    .period_i  (period_w),
    .wrap_o    (wrap_w),
    .en_o      (en_w)
  );

  swallow_clock_gate gate_i (
    .clk_i (clk_src),
    .en_i  (en_w),
    .clk_o (clk_gated)
  );

  assign stretch_active = active_w;
  assign clk_en         = en_w;

  p_status_r10: assert property (@(posedge clk_src) disable iff (rst)
    (!stretch_active && !wr_en) |=> !stretch_active);
endmodule

// File: tb/pulse_swallow_top_tb_top.sv
module pulse_swallow_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] ctrl_rdata;
  logic        stretch_active;
  logic        clk_en;
  logic        clk_gated;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 0;

  // behavioural reference state
  bit m_act = 0, m_en = 1, m_hp = 0, exp_gate = 1, g_seen = 0;
  int m_per = 0, m_pos = 0, m_pend = 0, m_rd = 0;

  always #4 clk = ~clk;

  pulse_swallow_top dut_i (
    .clk_src(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .ctrl_rdata(ctrl_rdata), .stretch_active(stretch_active),
    .clk_en(clk_en), .clk_gated(clk_gated)
  );

  always @(posedge clk_gated) g_seen = 1;

  always @(posedge clk) begin
    exp_gate = m_en;
    cyc++;
    if (rst) begin
      m_act = 0; m_en = 1; m_hp = 0; m_per = 0; m_pos = 0; m_rd = 0;
    end else begin
      m_en = 1;
      if (m_act) begin
        if (m_pos + 1 == m_per) begin
          m_en = 0;
          m_pos = 0;
          if (m_hp) begin
            m_per = m_pend; m_hp = 0;
            if (m_per == 0) m_act = 0;
          end
        end else m_pos++;
        if (wr_en) begin m_pend = wr_data; m_hp = 1; end
      end else if (wr_en && wr_data != 0) begin
        m_act = 1; m_per = wr_data; m_pos = 0; m_hp = 0;
      end
      if (wr_en) m_rd = wr_data;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cyc >= 3) begin
      chk(m_per == 1 && m_act ? "R9 clk_en" : "R2 clk_en", clk_en, m_en);
      chk("R10 stretch_active", stretch_active, m_act);
      chk("R7 ctrl_rdata", ctrl_rdata, m_rd);
      chk("R8 clk_gated pulse", g_seen, exp_gate);
    end
    g_seen = 0;
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input int v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v[15:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    // R5: reset state and idle pass-through
    chk("R5 reset active", stretch_active, 0);
    chk("R5 reset rdata", ctrl_rdata, 0);
    chk("R5 reset clk_en", clk_en, 1);
    idle(10);
    // R4: zero while idle
    wr(0);
    chk("R4 zero keeps idle", stretch_active, 0);
    idle(10);
    // R3, R1, R2: arm with 3
    wr(3);
    chk("R3 armed", stretch_active, 1);
    idle(30);
    // R6: deferred change to 5, then to 1 (R9), then 2
    wr(5); idle(40);
    wr(1); idle(12);
    wr(2); idle(20);
    // R6: held zero ends swallowing after the last gap
    wr(0); idle(15);
    chk("R6 stopped", stretch_active, 0);
    // writes at every offset inside a running group
    for (int off = 0; off < 9; off++) begin
      wr(7);
      idle(off);
      wr(4 + off);
      idle(30);
      wr(0);
      idle(20);
    end
    wr(16'hFFFF); idle(50);
    rst = 1'b1; idle(2); rst = 1'b0; idle(1);
    chk("R5 reset after run", stretch_active, 0);
    idle(10);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL R2 watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule